// File: doc/BRIEF.md
# Serial Transmit Flow Controller

This block decides, one character at a time, whether the local asynchronous transmitter may take its next byte. It watches the receive stream for two programmable control codes. One code ("pause") stops the flow of queued transmit data. The other ("resume") restarts it. Matched codes can be removed from the receive stream before it reaches the host. The host can also command the block to send either code to the far end, which lets the host throttle the remote side. Such a command goes out ahead of any queued data, and it goes out even while local data is paused.

Hardware handshake is a separate option and can be enabled together with the code-based mode. With it enabled, the block raises RTS whenever it has work. It hands a character to the transmitter only when RTS is high and CTS is asserted. RTS falls once the transmit side has been idle for a programmable number of clock cycles, standing for one character time.

The receive stream, the transmit queue and the transmitter each use a valid/ready stream interface. A valid byte is held until ready is seen. The block hands each character to the transmitter through a one-entry output register. Once a byte is in that register it counts as started: it is held stable until the transmitter takes it, whatever pause or CTS change follows. Stops therefore only take effect at character boundaries. Back-pressure on the receive output passes straight through to the receive input, except for stripped control codes, which are always accepted at once.

Top module: `txfc_flow_gate`

## Requirements
- R1: After reset, `txo_valid` and `rts` are 0 and data is not paused.
- R2: With code mode on, accepting a receive byte equal to the pause code stops `txq_ready` from the next cycle on. No new queue byte is loaded while paused.
- R3: With code mode on, accepting a receive byte equal to the resume code lets queued data flow again from the next cycle. If one accepted byte equals both codes, pause wins.
- R4: With code mode off, the codes are ordinary data. They are forwarded and cause no pause, and turning code mode off clears any pause.
- R5: With code mode and strip both on, a receive byte equal to either code is not forwarded (`rxo_valid` = 0) and is accepted at once (`rx_ready` = 1). With strip off it is forwarded like any byte.
- R6: A pulse on `spc_cmd` queues one special character: the resume code when `spc_kind` = 0, the pause code when `spc_kind` = 1. It is loaded before any queue data, and it is loaded even while paused. A second command before loading replaces the first.
- R7: A byte loaded into the output (`txo_valid` = 1) stays with `txo_data` unchanged until `txo_ready` is seen, regardless of pause or CTS.
- R8: With handshake mode on, no byte (queue or special) is loaded unless `rts` = 1 and `cts` = 1.
- R9: With handshake mode on, `rts` rises one cycle after work appears. Work means a pending special character, unpaused queue data, a full output register, or `tx_busy`. With handshake mode off, `rts` is 0 from the next cycle.
- R10: After work ends, `rts` stays high for exactly CHAR_CYCLES further cycles, then falls.
- R11: For a receive byte that is not stripped, `rxo_valid` follows `rx_valid` and `rx_ready` follows `rxo_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inband_en | input | 1 | Enable code-based pause/resume |
| outband_en | input | 1 | Enable RTS/CTS handshake |
| strip_en | input | 1 | Remove matched control codes from receive stream |
| xon_code | input | DW | Resume code |
| xoff_code | input | DW | Pause code |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | DW | Received byte |
| rx_ready | output | 1 | Received byte accepted |
| rxo_valid | output | 1 | Forwarded receive byte valid |
| rxo_data | output | DW | Forwarded receive byte |
| rxo_ready | input | 1 | Host side ready for receive byte |
| spc_cmd | input | 1 | One-cycle command to send a special character |
| spc_kind | input | 1 | 0 selects resume code, 1 selects pause code |
| txq_valid | input | 1 | Transmit queue byte valid |
| txq_data | input | DW | Transmit queue byte |
| txq_ready | output | 1 | Queue byte taken into output register |
| txo_valid | output | 1 | Character offered to transmitter |
| txo_data | output | DW | Character to transmit |
| txo_ready | input | 1 | Transmitter takes the character |
| tx_busy | input | 1 | Transmitter is shifting a character |
| cts | input | 1 | Clear-to-send from far end |
| rts | output | 1 | Request-to-send to far end |

## Verification
The bench aims at a pause code that arrives while a byte sits unaccepted in the output register. A design that retracts or alters that byte would break character integrity. It also issues a special-character command while data is paused; a design that gated specials with the pause would deadlock the remote side. The RTS idle window is measured to the exact cycle, since an off-by-one would cut the last character's stop time or hold the line too long. Stripping, with back-pressure on the receive output, would expose a stripped code that stalls the receive stream or leaks to the host.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
  typedef enum logic {
    SPC_RESUME = 1'b0,
    SPC_PAUSE  = 1'b1
  } spc_kind_e;

  typedef struct packed {
    logic inband;
    logic outband;
    logic strip;
  } fc_mode_t;
endpackage

// File: rtl/txfc_rx_watch.sv
module txfc_rx_watch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  txfc_pkg::fc_mode_t mode,
  input  logic [DW-1:0] xon_code,
  input  logic [DW-1:0] xoff_code,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rxo_valid,
  output logic [DW-1:0] rxo_data,
  input  logic          rxo_ready,
  output logic          paused
);
  logic hit_on, hit_off, drop, fire, paused_q;

  assign hit_on   = mode.inband && (rx_data == xon_code);
  assign hit_off  = mode.inband && (rx_data == xoff_code);
  assign drop     = mode.strip && (hit_on || hit_off);
  assign rxo_valid = rx_valid && !drop;
  assign rxo_data  = rx_data;
  assign rx_ready  = drop ? 1'b1 : rxo_ready;
  assign fire      = rx_valid && rx_ready;

  // pause code wins when one byte matches both codes
  always_ff @(posedge clk) begin
    if (!rst_n)                paused_q <= 1'b0;
    else if (!mode.inband)     paused_q <= 1'b0;
    else if (fire && hit_off)  paused_q <= 1'b1;
    else if (fire && hit_on)   paused_q <= 1'b0;
  end

  assign paused = paused_q;
endmodule

// File: rtl/txfc_tx_select.sv
module txfc_tx_select #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] xon_code,
  input  logic [DW-1:0] xoff_code,
  input  logic          spc_cmd,
  input  txfc_pkg::spc_kind_e spc_kind,
  input  logic          paused,
  input  logic          cts_ok,
  input  logic          txq_valid,
  input  logic [DW-1:0] txq_data,
  output logic          txq_ready,
  output logic          txo_valid,
  output logic [DW-1:0] txo_data,
  input  logic          txo_ready,
  output logic          spc_pend
);
  logic          full_q, pend_q, slot_free, take_spc, take_dat;
  logic [DW-1:0] data_q, pend_code_q;

  assign slot_free = !full_q || txo_ready;
  assign take_spc  = slot_free && pend_q && cts_ok;
  assign take_dat  = slot_free && !pend_q && txq_valid && !paused && cts_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_spc) begin
      full_q <= 1'b1;
      data_q <= pend_code_q;
    end else if (take_dat) begin
      full_q <= 1'b1;
      data_q <= txq_data;
    end else if (txo_ready) begin
      full_q <= 1'b0;
    end
  end

  // a new command overrides one still waiting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_code_q <= '0;
    end else if (spc_cmd) begin
      pend_q      <= 1'b1;
      pend_code_q <= (spc_kind == txfc_pkg::SPC_PAUSE) ? xoff_code : xon_code;
    end else if (take_spc) begin
      pend_q      <= 1'b0;
    end
  end

  assign txq_ready = take_dat;
  assign txo_valid = full_q;
  assign txo_data  = data_q;
  assign spc_pend  = pend_q;
endmodule

// File: rtl/txfc_rts_ctrl.sv
module txfc_rts_ctrl #(
  parameter int CHAR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic work,
  output logic rts
);
  localparam int CW = (CHAR_CYCLES > 1) ? $clog2(CHAR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHAR_CYCLES - 1);

  logic          rts_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      rts_q  <= 1'b0;
      idle_q <= '0;
    end else if (work) begin
      rts_q  <= 1'b1;
      idle_q <= '0;
    end else if (rts_q) begin
      if (idle_q == LAST) begin
        rts_q  <= 1'b0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign rts = rts_q;
endmodule

// File: rtl/txfc_flow_gate.sv
module txfc_flow_gate #(
  parameter int DW          = 8,
  parameter int CHAR_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inband_en,
  input  logic          outband_en,
  input  logic          strip_en,
  input  logic [DW-1:0] xon_code,
  input  logic [DW-1:0] xoff_code,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rxo_valid,
  output logic [DW-1:0] rxo_data,
  input  logic          rxo_ready,
  input  logic          spc_cmd,
  input  logic          spc_kind,
  input  logic          txq_valid,
  input  logic [DW-1:0] txq_data,
  output logic          txq_ready,
  output logic          txo_valid,
  output logic [DW-1:0] txo_data,
  input  logic          txo_ready,
  input  logic          tx_busy,
  input  logic          cts,
  output logic          rts
);
  txfc_pkg::fc_mode_t mode;
  logic paused, spc_pend, cts_ok, work;

  assign mode   = '{inband: inband_en, outband: outband_en, strip: strip_en};
  assign cts_ok = !outband_en || (rts && cts);
  assign work   = spc_pend || (txq_valid && !paused) || txo_valid || tx_busy;

  txfc_rx_watch #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .xon_code(xon_code), .xoff_code(xoff_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rxo_valid(rxo_valid), .rxo_data(rxo_data), .rxo_ready(rxo_ready),
    .paused(paused)
  );

  txfc_tx_select #(.DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .xon_code(xon_code), .xoff_code(xoff_code),
    .spc_cmd(spc_cmd), .spc_kind(txfc_pkg::spc_kind_e'(spc_kind)),
    .paused(paused), .cts_ok(cts_ok),
    .txq_valid(txq_valid), .txq_data(txq_data), .txq_ready(txq_ready),
    .txo_valid(txo_valid), .txo_data(txo_data), .txo_ready(txo_ready),
    .spc_pend(spc_pend)
  );

  txfc_rts_ctrl #(.CHAR_CYCLES(CHAR_CYCLES)) u_rts (
    .clk(clk), .rst_n(rst_n), .enable(outband_en), .work(work), .rts(rts)
  );
endmodule

// File: rtl/txfc_flow_gate_chk.sv
module txfc_flow_gate_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inband_en,
  input logic          outband_en,
  input logic          strip_en,
  input logic [DW-1:0] xon_code,
  input logic [DW-1:0] xoff_code,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rx_ready,
  input logic          rxo_valid,
  input logic          rxo_ready,
  input logic          txq_ready,
  input logic          txo_valid,
  input logic [DW-1:0] txo_data,
  input logic          txo_ready,
  input logic          cts,
  input logic          rts
);
  logic code_hit;
  assign code_hit = inband_en && (rx_data == xon_code || rx_data == xoff_code);

  // R7: an offered character is held until taken
  p_hold_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txo_valid && !txo_ready) |=> (txo_valid && $stable(txo_data)));

  // R8: loads only with RTS and CTS in handshake mode
  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txq_ready |-> (!outband_en || (rts && cts)));

  // R2: an accepted pause code blocks the queue on the next cycle
  p_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && inband_en && rx_data == xoff_code) |=> !txq_ready);

  // R9: RTS low once handshake mode is off
  p_rts_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !outband_en |=> !rts);

  // R5: stripped codes never reach the host and never stall
  p_strip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_en && rx_valid && code_hit) |-> (rx_ready && !rxo_valid));

  // R11: ordinary bytes pass back-pressure through
  p_backpress_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !(strip_en && code_hit)) |-> (rxo_valid && rx_ready == rxo_ready));
endmodule

bind txfc_flow_gate txfc_flow_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inband_en(inband_en), .outband_en(outband_en),
  .strip_en(strip_en), .xon_code(xon_code), .xoff_code(xoff_code),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .rxo_valid(rxo_valid), .rxo_ready(rxo_ready), .txq_ready(txq_ready),
  .txo_valid(txo_valid), .txo_data(txo_data), .txo_ready(txo_ready),
  .cts(cts), .rts(rts)
);

// File: tb/test_txfc_flow_gate.sv
`timescale 1ns/1ps
module test_txfc_flow_gate;
  localparam int DW = 8;
  localparam int CC = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, inband_en, outband_en, strip_en;
  logic [DW-1:0] xon_code, xoff_code, rx_data, rxo_data, txq_data, txo_data;
  logic rx_valid, rx_ready, rxo_valid, rxo_ready, spc_cmd, spc_kind;
  logic txq_valid, txq_ready, txo_valid, txo_ready, tx_busy, cts, rts;

  txfc_flow_gate #(.DW(DW), .CHAR_CYCLES(CC)) i_txfc_flow_gate (.*);

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_pause, m_full, m_spc, m_rts;
  logic [DW-1:0] m_data, m_spcd;
  int m_idle;
  bit e_on, e_off, e_drop, e_rxo_valid, e_rx_ready, e_ok, e_free, e_lspc, e_ldat, e_work;

  task automatic predict;
    e_on   = inband_en && rx_data == xon_code;
    e_off  = inband_en && rx_data == xoff_code;
    e_drop = strip_en && (e_on || e_off);
    e_rxo_valid = rx_valid && !e_drop;
    e_rx_ready  = e_drop ? 1'b1 : rxo_ready;
    e_ok   = !outband_en || (m_rts && cts);
    e_free = !m_full || txo_ready;
    e_lspc = e_free && m_spc && e_ok;
    e_ldat = e_free && !m_spc && txq_valid && !m_pause && e_ok;
    e_work = m_spc || (txq_valid && !m_pause) || m_full || tx_busy;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pause = 0; m_full = 0; m_spc = 0; m_rts = 0; m_idle = 0;
      m_data = '0; m_spcd = '0;
    end else begin
      bit fire;
      predict();
      fire = rx_valid && e_rx_ready;
      if (!inband_en) m_pause = 0;
      else if (fire && e_off) m_pause = 1;
      else if (fire && e_on) m_pause = 0;
      if (e_lspc) begin m_full = 1; m_data = m_spcd; end
      else if (e_ldat) begin m_full = 1; m_data = txq_data; end
      else if (txo_ready) m_full = 0;
      if (spc_cmd) begin m_spc = 1; m_spcd = spc_kind ? xoff_code : xon_code; end
      else if (e_lspc) m_spc = 0;
      if (!outband_en) begin m_rts = 0; m_idle = 0; end
      else if (e_work) begin m_rts = 1; m_idle = 0; end
      else if (m_rts) begin
        if (m_idle == CC - 1) begin m_rts = 0; m_idle = 0; end
        else m_idle++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      predict();
      chk("R11 rxo_valid", rxo_valid, e_rxo_valid);
      chk("R5 rx_ready", rx_ready, e_rx_ready);
      if (rxo_valid) chk("R11 rxo_data", rxo_data, rx_data);
      chk("R8 txq_ready", txq_ready, e_ldat);
      chk("R7 txo_valid", txo_valid, m_full);
      if (m_full) chk("R6 txo_data", txo_data, m_data);
      chk("R10 rts", rts, m_rts);
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic nx; @(negedge clk); endtask

  initial begin
    rst_n = 0; inband_en = 1; outband_en = 0; strip_en = 1;
    xon_code = 8'h11; xoff_code = 8'h13;
    rx_valid = 0; rx_data = 0; rxo_ready = 1; spc_cmd = 0; spc_kind = 0;
    txq_valid = 0; txq_data = 0; txo_ready = 1; tx_busy = 0; cts = 0;
    repeat (3) nx();
    rst_n = 1;
    nx();
    chk("R1 txo_valid", txo_valid, 0);
    chk("R1 rts", rts, 0);
    txq_valid = 1; txq_data = 8'h01; #1;
    chk("R1 not paused", txq_ready, 1);
    txq_valid = 0;
    nx(); nx();

    // pause code, stripped
    rx_valid = 1; rx_data = xoff_code; #1;
    chk("R5 strip rxo_valid", rxo_valid, 0);
    chk("R5 strip rx_ready", rx_ready, 1);
    nx();
    rx_valid = 0; txq_valid = 1; txq_data = 8'hA5; txo_ready = 1; #1;
    chk("R2 paused", txq_ready, 0);
    nx();
    spc_cmd = 1; spc_kind = 0;
    nx();
    spc_cmd = 0;
    nx();
    chk("R6 special valid", txo_valid, 1);
    chk("R6 special code", txo_data, 8'h11);
    chk("R6 data still paused", txq_ready, 0);
    rx_valid = 1; rx_data = xon_code;
    nx();
    rx_valid = 0; #1;
    chk("R3 resumed", txq_ready, 1);
    nx();
    chk("R3 data out", txo_data, 8'hA5);
    txq_data = 8'h5A; txo_ready = 0;
    rx_valid = 1; rx_data = xoff_code;
    nx();
    rx_valid = 0;
    chk("R7 held valid", txo_valid, 1);
    chk("R7 held data", txo_data, 8'hA5);
    txo_ready = 1;
    nx();
    chk("R2 no new load", txo_valid, 0);
    txq_valid = 0; rx_valid = 1; rx_data = xon_code;
    nx();
    rx_valid = 0;

    // receive back-pressure and strip off
    rx_valid = 1; rx_data = 8'h41; rxo_ready = 0; #1;
    chk("R11 forwarded", rxo_valid, 1);
    chk("R11 backpressure", rx_ready, 0);
    strip_en = 0; rx_data = xoff_code; #1;
    chk("R5 no strip fwd", rxo_valid, 1);
    chk("R5 no strip ready", rx_ready, 0);
    rx_valid = 0; rxo_ready = 1; strip_en = 1;
    nx();

    // code mode off
    inband_en = 0; rx_valid = 1; rx_data = xoff_code; #1;
    chk("R4 code forwarded", rxo_valid, 1);
    nx();
    rx_valid = 0; txq_valid = 1; txq_data = 8'h3C; #1;
    chk("R4 no pause", txq_ready, 1);
    nx();
    txq_valid = 0; inband_en = 1;
    nx();

    // handshake mode
    outband_en = 1; cts = 0; txq_valid = 1; txq_data = 8'h77;
    nx();
    chk("R9 rts rise", rts, 1);
    #1 chk("R8 cts low blocks", txq_ready, 0);
    repeat (3) nx();
    chk("R8 nothing sent", txo_valid, 0);
    cts = 1; #1;
    chk("R8 cts high loads", txq_ready, 1);
    nx();
    txq_valid = 0;
    chk("R8 char out", txo_data, 8'h77);
    nx();
    begin
      int n = 0;
      while (rts && n < 100) begin n++; nx(); end
      chk("R10 idle window", n, CC);
    end
    outband_en = 0;
    nx();
    chk("R9 rts off", rts, 0);
    cts = 0;

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      nx();
      if (i % 200 == 0) begin
        inband_en  = $urandom % 4 != 0;
        outband_en = $urandom % 2;
        strip_en   = $urandom % 2;
      end
      r = $urandom % 4;
      rx_valid  = $urandom % 2;
      rx_data   = (r == 0) ? xon_code : (r == 1) ? xoff_code : 8'($urandom);
      rxo_ready = $urandom % 4 != 0;
      spc_cmd   = $urandom % 16 == 0;
      spc_kind  = $urandom % 2;
      txq_valid = $urandom % 3 != 0;
      txq_data  = 8'($urandom);
      txo_ready = $urandom % 3 != 0;
      tx_busy   = $urandom % 5 == 0;
      cts       = $urandom % 4 != 0;
    end
    nx();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule